// File: doc/BRIEF.md
# Board Control and Status Register Bank

This block is a byte-wide bank of registers that a processor reaches over a simple local peripheral bus with chip select, read and write strobes. It gathers the board's static and slow signals into readable registers: jumper and switch positions, fuse health, flash busy, a debounced abort input, module presence flags and a configuration switch bank. It also produces the board's control outputs: a fail LED, masking of the thermostat interrupt, write enables for two flash banks, and a timed hard reset pulse started by software.

Two of its outputs combine software and hardware terms. Each flash bank is writable only when its software protect bit is clear and its protect jumper is open, and no write can override the jumper. The thermostat line reaches the interrupt output only while its mask bit is clear. A slow reference clock, divided from strobes of the UART oscillator, can be read live in the status register so software can time delays without a timer.

The reset register arms a small state machine with three states: IDLE (no pulse), HOLD (reset output asserted, cycles counted) and DONE (one cycle of recovery). The transitions are: IDLE to HOLD on a write of 1 to bit 7 of the reset register; HOLD to HOLD while fewer than RST_CYCLES cycles have passed; HOLD to DONE after the last asserted cycle; DONE to IDLE unconditionally. The bit it arms always reads 0.

Top module: `board_csr`

## Requirements
- R1: Offset 0 is read-only status; from bit 7 down it reads reference clock level, boot bank jumper, safe start jumper, abort_n, flash_busy_n, fuse_ok, srom_init, and bit 0 reads 0.
- R2: The reference clock level starts at 0 after reset and toggles after every REF_DIV/2 cycles in which osc_tick is 1 (REF_DIV = 64 by default), so it is osc_tick divided by REF_DIV; it never changes in a cycle with no tick.
- R3: Offset 1 is control; bits 7 (fail LED, 1 = lit), 6 (spare), 5 (bank A software protect), 4 (thermostat mask), 3 (bank B boot block software protect) are writable and reset to 1; bits 2 and 1 read the bank A and bank B protect jumpers; fail_led follows bit 7.
- R4: flash_a_wr_ok is 1 only when control bit 5 is 0 and hwp_a_hdr is 0.
- R5: For flash_b_addr at or above BOOTB_BASE (0xFFF00000), flash_b_wr_ok is 1 only when control bit 3 is 0 and hwp_b_hdr is 0; below that address it is always 1.
- R6: thermo_irq equals thermo_in while control bit 4 is 0 and is 0 while that bit is 1.
- R7: Writing a byte with bit 7 set to offset 2 asserts board_rst from the next cycle for exactly RST_CYCLES cycles; such writes while a pulse or its recovery cycle is in progress are ignored; offset 2 always reads 0.
- R8: Offset 4 reads presence: bit 0 pmc0_present_n, bit 1 pmc1_present_n, bit 2 xmod_present_n, bit 3 enum_rdy0, bit 4 enum_rdy1, bits 7..5 read 0.
- R9: Offset 5 reads the inverse of cfg_sw_on, so a switch that is ON reads 0.
- R10: Writes to offsets 0, 3, 4, 5, 6, 7 and to control bits 2..0 change nothing; offsets 3, 6 and 7 read 0; rdata is 0 whenever a read is not in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational during a read |
| osc_tick | input | 1 | One-cycle strobe per UART oscillator period |
| boot_bank_sel | input | 1 | Boot bank jumper (1 = bank B) |
| safe_start | input | 1 | Safe start jumper |
| abort_n | input | 1 | Debounced abort switch, 0 = pressed |
| flash_busy_n | input | 1 | Bank A flash status, 0 = busy |
| fuse_ok | input | 1 | 1 = all fuses intact |
| srom_init | input | 1 | 1 = controller initialised from serial ROM |
| hwp_a_hdr | input | 1 | 1 = bank A protect jumper fitted |
| hwp_b_hdr | input | 1 | 1 = bank B boot block protect jumper fitted |
| pmc0_present_n | input | 1 | 0 = module in slot 0 |
| pmc1_present_n | input | 1 | 0 = module in slot 1 |
| xmod_present_n | input | 1 | 0 = expansion module fitted |
| enum_rdy0 | input | 1 | Slot 0 module ready for enumeration |
| enum_rdy1 | input | 1 | Slot 1 module ready for enumeration |
| cfg_sw_on | input | 8 | Configuration switches, 1 = ON |
| thermo_in | input | 1 | Thermostat output |
| flash_b_addr | input | 32 | Address of a pending bank B write |
| flash_a_wr_ok | output | 1 | Bank A write permitted |
| flash_b_wr_ok | output | 1 | Bank B write to flash_b_addr permitted |
| fail_led | output | 1 | Board fail LED, 1 = lit |
| thermo_irq | output | 1 | Masked thermostat interrupt |
| board_rst | output | 1 | Hard board reset pulse |

## Verification
The reset sequencer and the bus meet when software writes the reset register again while a pulse is still running, or reads that register in the middle of a pulse. The bench issues a second arming write partway through a pulse and a read of offset 2 during the pulse, then counts asserted cycles of board_rst from outside: the width must still be exactly RST_CYCLES and the read must return 0. The reference divider likewise meets the bus when a status read lands right on the tick that flips the level; the bench reads status after 31 and after 32 ticks and expects bit 7 to change only at the second read.

// File: rtl/bcsr_pkg.sv
package bcsr_pkg;
    localparam int OFS_W = 3;
    localparam logic [OFS_W-1:0] OFS_STAT = 3'd0;
    localparam logic [OFS_W-1:0] OFS_CTRL = 3'd1;
    localparam logic [OFS_W-1:0] OFS_RST  = 3'd2;
    localparam logic [OFS_W-1:0] OFS_PRES = 3'd4;
    localparam logic [OFS_W-1:0] OFS_CFG  = 3'd5;

    // writable control bits: 7 led, 6 spare, 5 wp A, 4 thermo mask, 3 wp B boot
    localparam logic [7:0] CTRL_WMASK = 8'hF8;
    localparam int CB_LED = 7;
    localparam int CB_WPA = 5;
    localparam int CB_TMK = 4;
    localparam int CB_WPB = 3;
    localparam int RB_KICK = 7;

    typedef enum logic [1:0] {
        RS_IDLE = 2'd0,
        RS_HOLD = 2'd1,
        RS_DONE = 2'd2
    } rst_state_e;
endpackage

// File: rtl/bcsr_refdiv.sv
module bcsr_refdiv #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic lvl
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            lvl <= 1'b0;
        end else if (tick) begin
            if (cnt == CW'(HALF - 1)) begin
                cnt <= '0;
                lvl <= ~lvl;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcsr_rstseq.sv
module bcsr_rstseq
    import bcsr_pkg::*;
#(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic board_rst
);
    localparam int CW = $clog2(HOLD + 1);

    rst_state_e    state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == RS_HOLD) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RS_IDLE: if (kick) nxt = RS_HOLD;
            RS_HOLD: if (cnt == CW'(HOLD - 1)) nxt = RS_DONE;
            RS_DONE: nxt = RS_IDLE;
            default: nxt = RS_IDLE;
        endcase
    end

    always_comb begin
        board_rst = 1'b0;
        unique case (state)
            RS_HOLD: board_rst = 1'b1;
            default: board_rst = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcsr_wprot.sv
module bcsr_wprot #(
    parameter int             AW        = 32,
    parameter logic [AW-1:0]  BOOT_BASE = 'hFFF0_0000
) (
    input  logic          swp_a,
    input  logic          hwp_a,
    input  logic          swp_b,
    input  logic          hwp_b,
    input  logic [AW-1:0] b_addr,
    output logic          a_ok,
    output logic          b_ok
);
    logic b_in_boot;

    always_comb begin
        b_in_boot = (b_addr >= BOOT_BASE);
        a_ok      = ~swp_a & ~hwp_a;
        b_ok      = ~b_in_boot | (~swp_b & ~hwp_b);
    end
endmodule

// File: rtl/board_csr.sv
module board_csr
    import bcsr_pkg::*;
#(
    parameter int                  REF_DIV    = 64,
    parameter int                  RST_CYCLES = 16,
    parameter int                  FADDR_W    = 32,
    parameter logic [FADDR_W-1:0]  BOOTB_BASE = 'hFFF0_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cs,
    input  logic               rd,
    input  logic               wr,
    input  logic [2:0]         addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic               osc_tick,
    input  logic               boot_bank_sel,
    input  logic               safe_start,
    input  logic               abort_n,
    input  logic               flash_busy_n,
    input  logic               fuse_ok,
    input  logic               srom_init,
    input  logic               hwp_a_hdr,
    input  logic               hwp_b_hdr,
    input  logic               pmc0_present_n,
    input  logic               pmc1_present_n,
    input  logic               xmod_present_n,
    input  logic               enum_rdy0,
    input  logic               enum_rdy1,
    input  logic [7:0]         cfg_sw_on,
    input  logic               thermo_in,
    input  logic [FADDR_W-1:0] flash_b_addr,
    output logic               flash_a_wr_ok,
    output logic               flash_b_wr_ok,
    output logic               fail_led,
    output logic               thermo_irq,
    output logic               board_rst
);
    logic [7:0] ctrl_q;
    logic       ref_lvl;
    logic       wr_hit;
    logic       kick;
    logic [7:0] stat_v, ctrl_v, pres_v;

    assign wr_hit = cs & wr;
    assign kick   = wr_hit && (addr == OFS_RST) && wdata[RB_KICK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_WMASK;
        end else if (wr_hit && addr == OFS_CTRL) begin
            ctrl_q <= wdata & CTRL_WMASK;
        end
    end

    bcsr_refdiv #(.DIV(REF_DIV)) u_ref (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (osc_tick),
        .lvl  (ref_lvl)
    );

    bcsr_rstseq #(.HOLD(RST_CYCLES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick     (kick),
        .board_rst(board_rst)
    );

    bcsr_wprot #(.AW(FADDR_W), .BOOT_BASE(BOOTB_BASE)) u_wp (
        .swp_a (ctrl_q[CB_WPA]),
        .hwp_a (hwp_a_hdr),
        .swp_b (ctrl_q[CB_WPB]),
        .hwp_b (hwp_b_hdr),
        .b_addr(flash_b_addr),
        .a_ok  (flash_a_wr_ok),
        .b_ok  (flash_b_wr_ok)
    );

    always_comb begin
        fail_led   = ctrl_q[CB_LED];
        thermo_irq = thermo_in & ~ctrl_q[CB_TMK];
        stat_v = {ref_lvl, boot_bank_sel, safe_start, abort_n,
                  flash_busy_n, fuse_ok, srom_init, 1'b0};
        ctrl_v = (ctrl_q & CTRL_WMASK) | {5'b0, hwp_a_hdr, hwp_b_hdr, 1'b0};
        pres_v = {3'b0, enum_rdy1, enum_rdy0, xmod_present_n,
                  pmc1_present_n, pmc0_present_n};
        rdata = 8'h00;
        if (cs && rd) begin
            unique case (addr)
                OFS_STAT: rdata = stat_v;
                OFS_CTRL: rdata = ctrl_v;
                OFS_PRES: rdata = pres_v;
                OFS_CFG:  rdata = ~cfg_sw_on;
                default:  rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/bcsr_chk.sv
module bcsr_chk #(
    parameter int                 HOLD       = 16,
    parameter int                 FADDR_W    = 32,
    parameter logic [FADDR_W-1:0] BOOTB_BASE = 'hFFF0_0000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs,
    input logic               rd,
    input logic [2:0]         addr,
    input logic [7:0]         rdata,
    input logic               osc_tick,
    input logic               ref_lvl,
    input logic               hwp_a_hdr,
    input logic               hwp_b_hdr,
    input logic [FADDR_W-1:0] flash_b_addr,
    input logic               flash_a_wr_ok,
    input logic               flash_b_wr_ok,
    input logic               thermo_in,
    input logic               thermo_irq,
    input logic               board_rst
);
    localparam int RW = $clog2(HOLD + 2);
    logic [RW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run <= '0;
        else if (board_rst)  run <= run + 1'b1;
        else                 run <= '0;
    end

    p_stat_bit0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 3'd0) |-> (rdata[0] == 1'b0));

    p_ref_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> $stable(ref_lvl));

    p_hwp_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hwp_a_hdr |-> !flash_a_wr_ok);

    p_hwp_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hwp_b_hdr && flash_b_addr >= BOOTB_BASE) |-> !flash_b_wr_ok);

    p_low_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_b_addr < BOOTB_BASE) |-> flash_b_wr_ok);

    p_thermo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        thermo_irq |-> thermo_in);

    p_rst_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(board_rst) |-> (run == RW'(HOLD)));

    p_rst_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        board_rst |-> (run < RW'(HOLD)));

    p_rst_reads0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && rd && addr == 3'd2) |-> (rdata == 8'h00));
endmodule

bind board_csr bcsr_chk #(
    .HOLD      (RST_CYCLES),
    .FADDR_W   (FADDR_W),
    .BOOTB_BASE(BOOTB_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs           (cs),
    .rd           (rd),
    .addr         (addr),
    .rdata        (rdata),
    .osc_tick     (osc_tick),
    .ref_lvl      (ref_lvl),
    .hwp_a_hdr    (hwp_a_hdr),
    .hwp_b_hdr    (hwp_b_hdr),
    .flash_b_addr (flash_b_addr),
    .flash_a_wr_ok(flash_a_wr_ok),
    .flash_b_wr_ok(flash_b_wr_ok),
    .thermo_in    (thermo_in),
    .thermo_irq   (thermo_irq),
    .board_rst    (board_rst)
);

// File: tb/sim_board_csr.sv
module sim_board_csr;
    localparam int CLK_NS = 10;
    localparam int HOLD   = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [2:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        osc_tick = 1'b0;
    logic        boot_bank_sel = 1'b1, safe_start = 1'b0, abort_n = 1'b1;
    logic        flash_busy_n = 1'b1, fuse_ok = 1'b1, srom_init = 1'b0;
    logic        hwp_a_hdr = 1'b0, hwp_b_hdr = 1'b1;
    logic        pmc0_present_n = 1'b0, pmc1_present_n = 1'b1, xmod_present_n = 1'b0;
    logic        enum_rdy0 = 1'b1, enum_rdy1 = 1'b0;
    logic [7:0]  cfg_sw_on = 8'hA5;
    logic        thermo_in = 1'b0;
    logic [31:0] flash_b_addr = 32'hFFF0_0000;
    logic        flash_a_wr_ok, flash_b_wr_ok, fail_led, thermo_irq, board_rst;

    board_csr #(.REF_DIV(64), .RST_CYCLES(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .osc_tick(osc_tick),
        .boot_bank_sel(boot_bank_sel), .safe_start(safe_start), .abort_n(abort_n),
        .flash_busy_n(flash_busy_n), .fuse_ok(fuse_ok), .srom_init(srom_init),
        .hwp_a_hdr(hwp_a_hdr), .hwp_b_hdr(hwp_b_hdr),
        .pmc0_present_n(pmc0_present_n), .pmc1_present_n(pmc1_present_n),
        .xmod_present_n(xmod_present_n), .enum_rdy0(enum_rdy0), .enum_rdy1(enum_rdy1),
        .cfg_sw_on(cfg_sw_on), .thermo_in(thermo_in), .flash_b_addr(flash_b_addr),
        .flash_a_wr_ok(flash_a_wr_ok), .flash_b_wr_ok(flash_b_wr_ok),
        .fail_led(fail_led), .thermo_irq(thermo_irq), .board_rst(board_rst)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_run = 0;
    int n_fail = 0;
    int rst_hi = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: compares each read against the queued expectation
    always @(posedge clk) begin
        #1;
        if (cs && rd) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "unexpected read", {24'b0, rdata}, 32'h0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rdata == e, t, {24'b0, rdata}, {24'b0, e});
            end
        end
        if (board_rst) rst_hi++;
    end

    task automatic rd_exp(input logic [2:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        cs = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        osc_tick = 1'b1;
        repeat (n) @(negedge clk);
        osc_tick = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk(fail_led == 1'b1, "R3 led after reset", {31'b0, fail_led}, 32'h1);
        chk(flash_a_wr_ok == 1'b0, "R4 bank A protected after reset", {31'b0, flash_a_wr_ok}, 32'h0);
        chk(board_rst == 1'b0, "R7 no pulse after reset", {31'b0, board_rst}, 32'h0);
        rd_exp(3'd1, 8'hFA, "R3 ctrl reset value");
        rd_exp(3'd0, 8'h5C, "R1 status pattern 1");

        // R1 second pattern
        boot_bank_sel = 1'b0; safe_start = 1'b1; abort_n = 1'b0;
        flash_busy_n = 1'b0; fuse_ok = 1'b0; srom_init = 1'b1;
        rd_exp(3'd0, 8'h22, "R1 status pattern 2");

        // R2 reference clock divide
        ticks(31);
        rd_exp(3'd0, 8'h22, "R2 no toggle after 31 ticks");
        ticks(1);
        rd_exp(3'd0, 8'hA2, "R2 toggle on 32nd tick");
        ticks(32);
        rd_exp(3'd0, 8'h22, "R2 toggle back after 32 more");

        // R3/R4/R10 control writes
        wr_reg(3'd1, 8'h00);
        @(negedge clk);
        chk(fail_led == 1'b0, "R3 led cleared", {31'b0, fail_led}, 32'h0);
        chk(flash_a_wr_ok == 1'b1, "R4 bank A enabled", {31'b0, flash_a_wr_ok}, 32'h1);
        rd_exp(3'd1, 8'h02, "R3 ctrl after clear");
        wr_reg(3'd1, 8'h07);
        rd_exp(3'd1, 8'h02, "R10 ctrl bits 2..0 not writable");
        hwp_a_hdr = 1'b1;
        @(negedge clk);
        chk(flash_a_wr_ok == 1'b0, "R4 jumper overrides software", {31'b0, flash_a_wr_ok}, 32'h0);
        rd_exp(3'd1, 8'h06, "R3 jumper copies");
        hwp_a_hdr = 1'b0;

        // R5 bank B boot block
        @(negedge clk);
        chk(flash_b_wr_ok == 1'b0, "R5 jumper protects top block", {31'b0, flash_b_wr_ok}, 32'h0);
        hwp_b_hdr = 1'b0;
        @(negedge clk);
        chk(flash_b_wr_ok == 1'b1, "R5 top block writable", {31'b0, flash_b_wr_ok}, 32'h1);
        wr_reg(3'd1, 8'h08);
        @(negedge clk);
        chk(flash_b_wr_ok == 1'b0, "R5 software protects top block", {31'b0, flash_b_wr_ok}, 32'h0);
        flash_b_addr = 32'hFFEF_FFFF;
        @(negedge clk);
        chk(flash_b_wr_ok == 1'b1, "R5 below top block unprotected", {31'b0, flash_b_wr_ok}, 32'h1);

        // R6 thermostat mask
        thermo_in = 1'b1;
        @(negedge clk);
        chk(thermo_irq == 1'b1, "R6 unmasked passes", {31'b0, thermo_irq}, 32'h1);
        wr_reg(3'd1, 8'h18);
        @(negedge clk);
        chk(thermo_irq == 1'b0, "R6 masked blocks", {31'b0, thermo_irq}, 32'h0);
        thermo_in = 1'b0;

        // R8 presence, R9 switches
        rd_exp(3'd4, 8'h0A, "R8 presence pattern 1");
        pmc0_present_n = 1'b1; pmc1_present_n = 1'b0; xmod_present_n = 1'b1;
        enum_rdy0 = 1'b0; enum_rdy1 = 1'b1;
        rd_exp(3'd4, 8'h15, "R8 presence pattern 2");
        rd_exp(3'd5, 8'h5A, "R9 switches inverted A5");
        cfg_sw_on = 8'h0F;
        rd_exp(3'd5, 8'hF0, "R9 switches inverted 0F");

        // R10 ignored writes and empty offsets
        wr_reg(3'd0, 8'hFF);
        wr_reg(3'd4, 8'hFF);
        wr_reg(3'd3, 8'hFF);
        rd_exp(3'd0, 8'h22, "R10 status write ignored");
        rd_exp(3'd4, 8'h15, "R10 presence write ignored");
        rd_exp(3'd3, 8'h00, "R10 offset 3 reads 0");
        rd_exp(3'd6, 8'h00, "R10 offset 6 reads 0");
        rd_exp(3'd7, 8'h00, "R10 offset 7 reads 0");
        rd_exp(3'd1, 8'h18, "R10 ctrl unchanged");
        @(negedge clk);
        chk(rdata == 8'h00, "R10 idle rdata", {24'b0, rdata}, 32'h0);

        // R7 reset pulse
        rst_hi = 0;
        wr_reg(3'd2, 8'h7F);
        repeat (HOLD + 4) @(negedge clk);
        chk(rst_hi == 0, "R7 bit7 clear does nothing", rst_hi, 0);

        rst_hi = 0;
        wr_reg(3'd2, 8'h80);
        chk(board_rst == 1'b1, "R7 pulse starts next cycle", {31'b0, board_rst}, 32'h1);
        repeat (HOLD + 4) @(negedge clk);
        chk(rst_hi == HOLD, "R7 pulse width", rst_hi, HOLD);

        rst_hi = 0;
        wr_reg(3'd2, 8'h80);
        repeat (4) @(negedge clk);
        wr_reg(3'd2, 8'h80);
        rd_exp(3'd2, 8'h00, "R7 reads 0 during pulse");
        repeat (HOLD + 4) @(negedge clk);
        chk(rst_hi == HOLD, "R7 retrigger ignored", rst_hi, HOLD);
        chk(board_rst == 1'b0, "R7 pulse released", {31'b0, board_rst}, 32'h0);

        @(negedge clk);
        chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule